// File: doc/BRIEF.md
# Deferred Manual Reference Switchover Controller

This block chooses one of two reference clocks for a downstream clock consumer. A manual select level picks the reference. A change of that level does not switch the output at once. The block records the request and raises a busy flag. It moves to the other reference only at a safe point: the first sampling cycle in which both references are seen rising together, while an external opportunity qualifier is high and neither reference is flagged as lost. Because the switch lands on coincident rising edges, the downstream clock sees little disturbance.

A loss flag on either reference stalls a pending request, and the current reference stays in use. When the flags clear, the request completes at the next safe point. Only reset drops a pending request. While reset is held, the active reference follows the raw select level directly.

All logic runs on one sampling clock. The loss flags and the qualifier are synchronous to that clock. The select input and both reference clocks are resynchronised inside the block.

Top module: `refSwitchover`

## Requirements
- R1: While reset is held, `activeRef` equals the raw `selIn` level on each sampling edge and `switchBusy` is 0.
- R2: A change on `selIn` to a level that differs from `activeRef` leaves `activeRef` unchanged and sets `switchBusy` to 1 within 4 sampling cycles.
- R3: A pending switch commits only in a cycle where the synchronised rising edges of both references fall in the same sampling cycle. Rises that are several cycles apart do not commit it.
- R4: While `switchOk` is 0, a pending switch does not commit, even at a coincident rising edge.
- R5: On commit, `activeRef` takes the requested level (0 means reference 0, 1 means reference 1) on the same edge where `switchBusy` falls. `activeRef` never changes at any other time outside reset.
- R6: While `lossRef0` or `lossRef1` is 1, a pending switch stalls and keeps the current reference. It completes at the next safe point after both flags clear.
- R7: Changes on `selIn` while `switchBusy` is 1 are ignored, and the original target is kept. A later `selIn` edge to the level `activeRef` already holds starts no request.
- R8: Reset cancels a pending request. After release, no switch takes place unless a new request is made.
- R9: `clkOut` carries `refClk0` when `activeRef` is 0 and `refClk1` when `activeRef` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Synchronous active-low reset |
| refClk0 | input | 1 | Reference clock 0 |
| refClk1 | input | 1 | Reference clock 1 |
| lossRef0 | input | 1 | Loss flag for reference 0 |
| lossRef1 | input | 1 | Loss flag for reference 1 |
| selIn | input | 1 | Manual reference select level |
| switchOk | input | 1 | Switch-opportunity qualifier |
| clkOut | output | 1 | Selected reference clock |
| activeRef | output | 1 | Reference in use (0 or 1) |
| switchBusy | output | 1 | Switchover pending |

## Verification
The bench offsets the rising edges of the two references by a few cycles. A design that commits on any edge, or on the edge of one reference alone, would switch there. It holds a loss flag on the requested reference and then on the active one: a design that ignored loss would switch onto a dead or abandoned reference, and one that dropped the request would never finish after recovery. It toggles the select input back while busy and then applies reset during a stalled request. A design that retargeted on the second edge, or kept a stale request across reset, would end on the wrong reference or show a spurious busy period.

// File: rtl/refsw_pkg.sv
package refsw_pkg;

  typedef enum logic [0:0] {
    SW_IDLE    = 1'b0,
    SW_PENDING = 1'b1
  } swState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic commit;
    logic target;
  } swStrobe_t;

endpackage

// File: rtl/refswEdgeSync.sv
module refswEdgeSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic initVal,
  input  logic d,
  output logic q,
  output logic toggle
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] pipe;
  logic          prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= initVal;
        else       pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= {STAGES{initVal}};
        else       pipe <= {pipe[LAST-1:0], d};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prev <= initVal;
    else       prev <= pipe[LAST];
  end

  assign q      = pipe[LAST];
  assign toggle = pipe[LAST] ^ prev;
endmodule

// File: rtl/refswDatapath.sv
module refswDatapath
  import refsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_REFS    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selIn,
  input  logic [NUM_REFS-1:0] refClkVec,
  input  swStrobe_t           strobe,
  output logic                selSync,
  output logic                selEdge,
  output logic                bothRise,
  output logic                activeRef,
  output logic                clkOut
);
  logic [NUM_REFS-1:0] refQ;
  logic [NUM_REFS-1:0] refToggle;
  logic [NUM_REFS-1:0] refRise;

  // select input: chain preloaded with the raw level in reset,
  // so releasing reset creates no edge
  refswEdgeSync #(.STAGES(SYNC_STAGES)) u_selSync (
    .clk    (clk),
    .rstN   (rstN),
    .initVal(selIn),
    .d      (selIn),
    .q      (selSync),
    .toggle (selEdge)
  );

  for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
    refswEdgeSync #(.STAGES(SYNC_STAGES)) u_refSync (
      .clk    (clk),
      .rstN   (rstN),
      .initVal(1'b0),
      .d      (refClkVec[i]),
      .q      (refQ[i]),
      .toggle (refToggle[i])
    );
    assign refRise[i] = refQ[i] & refToggle[i];
  end

  assign bothRise = &refRise;

  always_ff @(posedge clk) begin
    if (!rstN)              activeRef <= selIn;
    else if (strobe.commit) activeRef <= strobe.target;
  end

  assign clkOut = activeRef ? refClkVec[1] : refClkVec[0];
endmodule

// File: rtl/refswControl.sv
module refswControl
  import refsw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      selSync,
  input  logic      selEdge,
  input  logic      bothRise,
  input  logic      activeRef,
  input  logic      switchOk,
  input  logic      lossRef0,
  input  logic      lossRef1,
  output swStrobe_t strobe,
  output logic      switchBusy
);
  swState_e state;
  swState_e stateNext;
  logic     target;
  logic     anyLoss;
  logic     safePoint;
  logic     newRequest;

  assign anyLoss    = lossRef0 | lossRef1;
  assign safePoint  = bothRise & switchOk & ~anyLoss;
  assign newRequest = selEdge & (selSync != activeRef);

  always_comb begin
    stateNext     = state;
    strobe.commit = 1'b0;
    strobe.target = target;
    unique case (state)
      SW_IDLE:    if (newRequest) stateNext = SW_PENDING;
      SW_PENDING: if (safePoint) begin
        strobe.commit = 1'b1;
        stateNext     = SW_IDLE;
      end
      default:    stateNext = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= SW_IDLE;
      target <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == SW_IDLE && newRequest) target <= selSync;
    end
  end

  assign switchBusy = (state == SW_PENDING);
endmodule

// File: rtl/refSwitchover.sv
module refSwitchover
  import refsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refClk0,
  input  logic refClk1,
  input  logic lossRef0,
  input  logic lossRef1,
  input  logic selIn,
  input  logic switchOk,
  output logic clkOut,
  output logic activeRef,
  output logic switchBusy
);
  swStrobe_t strobe;
  logic      selSync;
  logic      selEdge;
  logic      bothRise;

  refswDatapath #(.SYNC_STAGES(SYNC_STAGES), .NUM_REFS(2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .selIn    (selIn),
    .refClkVec({refClk1, refClk0}),
    .strobe   (strobe),
    .selSync  (selSync),
    .selEdge  (selEdge),
    .bothRise (bothRise),
    .activeRef(activeRef),
    .clkOut   (clkOut)
  );

  refswControl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .selSync   (selSync),
    .selEdge   (selEdge),
    .bothRise  (bothRise),
    .activeRef (activeRef),
    .switchOk  (switchOk),
    .lossRef0  (lossRef0),
    .lossRef1  (lossRef1),
    .strobe    (strobe),
    .switchBusy(switchBusy)
  );
endmodule

// File: rtl/refSwitchover_chk.sv
module refSwitchover_chk (
  input logic clk,
  input logic rstN,
  input logic lossRef0,
  input logic lossRef1,
  input logic switchOk,
  input logic activeRef,
  input logic switchBusy
);
  AST_NO_SWITCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(switchBusy)) |-> (activeRef == $past(activeRef))); // R2

  AST_COMMIT_FLIPS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $fell(switchBusy)) |-> (activeRef != $past(activeRef))); // R5

  AST_CHANGE_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (activeRef != $past(activeRef))) |-> $fell(switchBusy)); // R5

  AST_STALL_ON_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (switchBusy && (lossRef0 || lossRef1)) |=> switchBusy); // R6

  AST_HOLD_WITHOUT_OK: assert property (@(posedge clk) disable iff (!rstN)
    (switchBusy && !switchOk) |=> switchBusy); // R4
endmodule

bind refSwitchover refSwitchover_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lossRef0  (lossRef0),
  .lossRef1  (lossRef1),
  .switchOk  (switchOk),
  .activeRef (activeRef),
  .switchBusy(switchBusy)
);

// File: tb/refSwitchover_tb.sv
module refSwitchover_tb;
  logic clk = 1'b0;
  logic rstN, refClk0, refClk1, lossRef0, lossRef1, selIn, switchOk;
  logic clkOut, activeRef, switchBusy;
  int   nRun  = 0;
  int   nFail = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;

  refSwitchover u_dut (
    .clk(clk), .rstN(rstN), .refClk0(refClk0), .refClk1(refClk1),
    .lossRef0(lossRef0), .lossRef1(lossRef1), .selIn(selIn),
    .switchOk(switchOk), .clkOut(clkOut), .activeRef(activeRef),
    .switchBusy(switchBusy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("[TB] FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseBoth();
    refClk0 = 1'b1; refClk1 = 1'b1; waitCyc(5);
    refClk0 = 1'b0; refClk1 = 1'b0; waitCyc(5);
  endtask

  task automatic pulseSkewed();
    refClk0 = 1'b1; waitCyc(3);
    refClk1 = 1'b1; waitCyc(5);
    refClk0 = 1'b0; refClk1 = 1'b0; waitCyc(5);
  endtask

  task automatic t_reset();
    rstN = 1'b0; selIn = 1'b1; waitCyc(2);
    check("R1", "active in reset sel=1", activeRef, 1);
    check("R1", "busy in reset", switchBusy, 0);
    selIn = 1'b0; waitCyc(2);
    check("R1", "active in reset sel=0", activeRef, 0);
    rstN = 1'b1; waitCyc(3);
  endtask

  task automatic t_deferred();
    selIn = 1'b1; waitCyc(1);
    check("R2", "active right after change", activeRef, 0);
    waitCyc(4);
    check("R2", "busy after change", switchBusy, 1);
    check("R2", "active still old", activeRef, 0);
    pulseSkewed();
    check("R3", "skewed rises keep busy", switchBusy, 1);
    check("R3", "skewed rises keep active", activeRef, 0);
    switchOk = 1'b0; pulseBoth();
    check("R4", "no qualifier keeps busy", switchBusy, 1);
    check("R4", "no qualifier keeps active", activeRef, 0);
    switchOk = 1'b1; pulseBoth();
    check("R5", "busy cleared at commit", switchBusy, 0);
    check("R3", "active switched at coincident rise", activeRef, 1);
    refClk0 = 1'b0; refClk1 = 1'b1; waitCyc(1);
    check("R9", "clkOut follows ref1 high", clkOut, 1);
    refClk0 = 1'b1; refClk1 = 1'b0; waitCyc(1);
    check("R9", "clkOut follows ref1 low", clkOut, 0);
    refClk0 = 1'b0; waitCyc(3);
  endtask

  task automatic t_ignore();
    selIn = 1'b0; waitCyc(5);
    check("R7", "busy for request to 0", switchBusy, 1);
    selIn = 1'b1; waitCyc(5);
    check("R7", "toggle back keeps busy", switchBusy, 1);
    pulseBoth();
    check("R7", "original target kept", activeRef, 0);
    check("R7", "busy cleared", switchBusy, 0);
    pulseBoth();
    check("R7", "stale select starts nothing", activeRef, 0);
    selIn = 1'b0; waitCyc(5);
    check("R7", "edge to current level no request", switchBusy, 0);
    refClk0 = 1'b1; waitCyc(1);
    check("R9", "clkOut follows ref0", clkOut, 1);
    refClk0 = 1'b0; waitCyc(3);
  endtask

  task automatic t_loss();
    selIn = 1'b1; waitCyc(5);
    lossRef1 = 1'b1; pulseBoth();
    check("R6", "requested ref lost stalls", switchBusy, 1);
    check("R6", "requested ref lost keeps active", activeRef, 0);
    lossRef1 = 1'b0; lossRef0 = 1'b1; pulseBoth();
    check("R6", "active ref lost stalls", switchBusy, 1);
    check("R6", "active ref lost keeps active", activeRef, 0);
    lossRef0 = 1'b0; pulseBoth();
    check("R6", "completes after recovery", activeRef, 1);
    check("R6", "busy cleared after recovery", switchBusy, 0);
  endtask

  task automatic t_cancel();
    selIn = 1'b0; waitCyc(5);
    check("R8", "pending before reset", switchBusy, 1);
    lossRef0 = 1'b1; selIn = 1'b1; pulseBoth();
    check("R8", "still stalled", switchBusy, 1);
    rstN = 1'b0; waitCyc(2);
    check("R8", "reset clears busy", switchBusy, 0);
    check("R1", "reset takes select level", activeRef, 1);
    rstN = 1'b1; lossRef0 = 1'b0; waitCyc(3);
    pulseBoth(); pulseBoth();
    check("R8", "cancelled request not executed", activeRef, 1);
    check("R8", "no busy after release", switchBusy, 0);
  endtask

  initial begin
    refClk0 = 1'b0; refClk1 = 1'b0; lossRef0 = 1'b0; lossRef1 = 1'b0;
    switchOk = 1'b1; selIn = 1'b0; rstN = 1'b0;
    waitCyc(1);
    t_reset();
    t_deferred();
    t_ignore();
    t_loss();
    t_cancel();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("[TB] FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule